// File: doc/BRIEF.md
# Programmable Interval Clock

This block is a memory-mapped interval timer with three word registers on a simple synchronous register bus: a control/status word, a count-set buffer and a live counter. A 16-bit counter counts up or down on tick strobes from one of four timebase inputs. The active input is chosen by a two-bit rate field. Each input is synchronized and edge-detected inside the block. The timebases are produced elsewhere and reach the block only as strobe inputs.

When the counter reaches zero, the block sets a done flag. If done is still set from an earlier zero, it sets an error flag instead. When interrupts are enabled, it also raises its interrupt line. In repeat mode the counter reloads from the buffer. In single mode the buffer is cleared and the timer stops itself. Reading the status word clears the flags. While the timer is stopped, software can step the counter by exactly one count through a status write.

Top module: `rtclk_top`

## Requirements
- R1: After a synchronous reset, the status word, the buffer and the counter are zero and `irq` is low.
- R2: A status write stores only the writable fields: run (bit 0), rate (bits 2:1), repeat (bit 3), count up (bit 4) and interrupt enable (bit 6). It clears done (bit 7), error (bit 15) and `irq`. A status read returns bits 5 and 8..14 as zero.
- R3: Address bits [2:1] select the register: 0 is status, 1 is the buffer, 2 is the counter. Reads of the buffer and of selector 3 return zero. Writes to the counter and to selector 3 have no effect.
- R4: A buffer write loads the written value into both the buffer and the counter, and clears done, error and `irq`.
- R5: While run is 1, each rising edge on `tb_in[k]` advances the counter by one, where k is the rate field (0..3). The counter counts down when bit 4 is 0 and up when bit 4 is 1, modulo 2^16. Edges on inputs that are not selected, and all edges while run is 0, change nothing.
- R6: When a count reaches zero, done is set. If done was already set, error is set instead. `irq` rises if interrupt enable is 1.
- R7: On reaching zero in repeat mode, the counter reloads from the buffer. In single mode, the buffer is cleared, run is cleared and later edges have no effect.
- R8: A status read returns the word as it stood before the read, then clears done, error and `irq`. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R9: A status write that leaves run at 0 with bit 5 set applies exactly one count at once, using the newly written direction, mode and enable.
- R10: A status write with both run and bit 5 set does not step the counter.
- R11: A status write that changes the rate or takes run from 0 to 1 discards an input edge that is still inside the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte address; bits [2:1] select the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tb_in | input | 4 | Asynchronous timebase strobes |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an edge that is caught inside the synchronizer at the moment software restarts the timer. The bench raises a timebase input and issues the run-starting status write on the very next cycle. It then confirms that the counter never moves, and that a later clean edge still counts. The double-zero error path is also hard to reach. The bench drives it with a repeat-mode buffer of one and two back-to-back edges, before any status read can clear done. Single-mode buffer clearing cannot be seen through a read, so the bench exposes it with a manual repeat-mode step that reloads the cleared buffer.

// File: rtl/rtclk_pkg.sv
package rtclk_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int B_RUN  = 0;
  localparam int B_RLO  = 1;
  localparam int B_RHI  = 2;
  localparam int B_RPT  = 3;
  localparam int B_UP   = 4;
  localparam int B_STEP = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
endpackage

// File: rtl/rtclk_tbsel.sv
module rtclk_tbsel #(
  parameter int NSRC = 4,
  parameter int SYNC = 2,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [SW-1:0]   sel,
  input  logic            flush,
  output logic            tick
);
  logic [NSRC-1:0] edge_w;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      logic [SYNC:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe <= '0;
        end else begin
          pipe <= {pipe[SYNC-1:0], src_in[g]};
          // treat the in-flight level as already seen
          if (flush) pipe[SYNC] <= 1'b1;
        end
      end
      assign edge_w[g] = pipe[SYNC-1] & ~pipe[SYNC];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        tick <= 1'b0;
    else if (flush) tick <= 1'b0;
    else            tick <= edge_w[sel];
  end
endmodule

// File: rtl/rtclk_core.sv
module rtclk_core
  import rtclk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stat,
  input  logic         wr_buf,
  input  logic         rd_stat,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] stat,
  output logic [W-1:0] cnt,
  output logic         irq
);
  localparam int B_ERR = W - 1;
  localparam logic [W-1:0] WMASK = W'((1 << B_RUN) | (1 << B_RLO) | (1 << B_RHI) |
                                      (1 << B_RPT) | (1 << B_UP)  | (1 << B_IE));

  logic [W-1:0] ctrl_q, buf_q, cnt_q;
  logic         done_q, err_q, irq_q;

  logic [W-1:0] ctrl_n, buf_n, cnt_n, step_v;
  logic         done_n, err_n, irq_n, step;

  always_comb begin
    ctrl_n = ctrl_q;
    buf_n  = buf_q;
    cnt_n  = cnt_q;
    done_n = done_q;
    err_n  = err_q;
    irq_n  = irq_q;
    if (wr_stat) begin
      ctrl_n = wdata & WMASK;
      done_n = 1'b0;
      err_n  = 1'b0;
      irq_n  = 1'b0;
    end
    if (wr_buf) begin
      buf_n  = wdata;
      cnt_n  = wdata;
      done_n = 1'b0;
      err_n  = 1'b0;
      irq_n  = 1'b0;
    end
    if (rd_stat) begin
      done_n = 1'b0;
      err_n  = 1'b0;
      irq_n  = 1'b0;
    end
    // manual step only on a stopped write; auto ticks lose to bus writes
    step = (wr_stat & ~wdata[B_RUN] & wdata[B_STEP]) |
           (tick & ~wr_stat & ~wr_buf & ctrl_q[B_RUN]);
    step_v = ctrl_n[B_UP] ? cnt_n + W'(1) : cnt_n - W'(1);
    if (step) begin
      cnt_n = step_v;
      if (step_v == '0) begin
        if (done_n) err_n = 1'b1;
        else        done_n = 1'b1;
        if (ctrl_n[B_IE]) irq_n = 1'b1;
        if (ctrl_n[B_RPT]) begin
          cnt_n = buf_n;
        end else begin
          buf_n         = '0;
          ctrl_n[B_RUN] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      buf_q  <= buf_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      err_q  <= err_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    stat         = ctrl_q;
    stat[B_DONE] = done_q;
    stat[B_ERR]  = err_q;
  end
  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/rtclk_top.sv
module rtclk_top
  import rtclk_pkg::*;
#(
  parameter int W    = 16,
  parameter int NSRC = 4,
  parameter int SYNC = 2,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [NSRC-1:0] tb_in,
  output logic            irq
);
  localparam int RW = $clog2(NSRC);
  localparam logic [W-1:0] RMASK = W'((1 << (B_DONE + 1)) - 1) | (W'(1) << (W - 1));

  reg_sel_e      sel;
  logic          wr_stat, wr_buf, rd_stat, flush, tick_w;
  logic [W-1:0]  stat_w, cnt_w;
  logic [RW-1:0] rate_w, rate_new;

  assign sel      = reg_sel_e'(bus_addr[2:1]);
  assign wr_stat  = bus_wr && sel == SEL_STAT;
  assign wr_buf   = bus_wr && sel == SEL_BUF;
  assign rd_stat  = bus_rd && !bus_wr && sel == SEL_STAT;
  assign rate_w   = stat_w[B_RLO +: RW];
  assign rate_new = bus_wdata[B_RLO +: RW];
  assign flush    = wr_stat && ((rate_new != rate_w) ||
                                (bus_wdata[B_RUN] && !stat_w[B_RUN]));

  rtclk_tbsel #(.NSRC(NSRC), .SYNC(SYNC)) i_tbsel (
    .clk   (clk),
    .rst   (rst),
    .src_in(tb_in),
    .sel   (rate_w),
    .flush (flush),
    .tick  (tick_w)
  );

  rtclk_core #(.W(W)) i_core (
    .clk    (clk),
    .rst    (rst),
    .wr_stat(wr_stat),
    .wr_buf (wr_buf),
    .rd_stat(rd_stat),
    .wdata  (bus_wdata),
    .tick   (tick_w),
    .stat   (stat_w),
    .cnt    (cnt_w),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        SEL_STAT: bus_rdata <= stat_w & RMASK;
        SEL_CNT:  bus_rdata <= cnt_w;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtclk_chk.sv
module rtclk_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   bus_addr,
  input logic         bus_rd,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] stat,
  input logic [W-1:0] cnt,
  input logic         tick,
  input logic         irq
);
  // R6: error and interrupt only ever accompany done
  a_r6_err_implies_done: assert property (@(posedge clk) disable iff (rst)
    stat[W-1] |-> stat[7]);
  a_r6_irq_implies_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat[7]);
  // R4: buffer write lands in the counter
  a_r4_buf_loads_cnt: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[2:1] == 2'd1) |=> cnt == $past(bus_wdata));
  // R3: counter write alone leaves the count
  a_r3_cnt_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[2:1] == 2'd2 && !tick) |=> $stable(cnt));
  // R8: status read with no tick clears flags and irq
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[2:1] == 2'd0 && !tick) |=> (!stat[7] && !irq));
  // R5: stopped and not written, the counter holds
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!stat[0] && !bus_wr) |=> $stable(cnt));
endmodule

bind rtclk_top rtclk_chk #(.W(W)) i_rtclk_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .stat     (stat_w),
  .cnt      (cnt_w),
  .tick     (tick_w),
  .irq      (irq)
);

// File: tb/test_rtclk_top.sv
`timescale 1ns/1ps
module test_rtclk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  tb_in = '0;
  logic        irq;
  int          tests = 0, fails = 0;

  always #2 clk = ~clk;

  rtclk_top i_rtclk_top (.*);

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] bufv;
    logic [1:0]  src;
    logic [3:0]  n;
    logic [15:0] cnt;
    logic [15:0] stat;
    logic        irq;
  } vec_t;

  // R5 R6 R7: rate select, direction, zero handling, repeat/single
  localparam vec_t VECS [7] = '{
    '{16'h0001, 16'h000A, 2'd0, 4'd3, 16'h0007, 16'h0001, 1'b0},
    '{16'h0013, 16'hFFFE, 2'd1, 4'd1, 16'hFFFF, 16'h0013, 1'b0},
    '{16'h0055, 16'hFFFE, 2'd2, 4'd2, 16'h0000, 16'h00D4, 1'b1},
    '{16'h000F, 16'h0002, 2'd3, 4'd2, 16'h0002, 16'h008F, 1'b0},
    '{16'h0001, 16'h0005, 2'd1, 4'd2, 16'h0005, 16'h0001, 1'b0},
    '{16'h0009, 16'h0001, 2'd0, 4'd2, 16'h0001, 16'h8089, 1'b0},
    '{16'h0049, 16'h0001, 2'd0, 4'd1, 16'h0001, 16'h00C9, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    tb_in[k] = 1'b1;
    repeat (2) @(negedge clk);
    tb_in[k] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, d); chk("R1 status", d, 16'h0000);
    rd(3'd4, d); chk("R1 counter", d, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 writable mask
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); chk("R2 mask", d, 16'h005F);
    wr(3'd0, 16'h0000);

    // R3 / R4 decode and buffer load
    wr(3'd2, 16'h1234);
    rd(3'd2, d); chk("R3 buffer reads zero", d, 16'h0000);
    rd(3'd4, d); chk("R4 counter loaded", d, 16'h1234);
    wr(3'd4, 16'h5555);
    wr(3'd6, 16'hAAAA);
    rd(3'd4, d); chk("R3 counter write ignored", d, 16'h1234);
    rd(3'd6, d); chk("R3 selector 3 reads zero", d, 16'h0000);

    // R9 manual step down then up
    wr(3'd0, 16'h0020);
    rd(3'd4, d); chk("R9 step down", d, 16'h1233);
    wr(3'd0, 16'h0030);
    rd(3'd4, d); chk("R9 step up", d, 16'h1234);
    // R10 step request with run set
    wr(3'd0, 16'h0021);
    rd(3'd4, d); chk("R10 no step while running", d, 16'h1234);
    wr(3'd0, 16'h0000);
    // R5 no count while stopped
    pulse(0);
    rd(3'd4, d); chk("R5 stopped", d, 16'h1234);

    // R9 / R6 step to zero with interrupt, then R4 clears flags
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h0060);
    chk("R6 irq on step zero", {15'd0, irq}, 16'h0001);
    wr(3'd2, 16'h0003);
    chk("R4 irq cleared", {15'd0, irq}, 16'h0000);
    rd(3'd0, d); chk("R4 done cleared", d, 16'h0040);

    // R7 single mode stops and clears buffer
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h0005);
    pulse(2); pulse(2); pulse(2);
    rd(3'd4, d); chk("R7 single stops at zero", d, 16'h0000);
    rd(3'd0, d); chk("R7 run cleared", d, 16'h0084);
    wr(3'd0, 16'h0030);
    wr(3'd0, 16'h0028);
    rd(3'd4, d); chk("R7 buffer cleared", d, 16'h0000);

    // R11 edge caught in the synchronizer at run start
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0010);
    @(negedge clk);
    tb_in[0] = 1'b1;
    wr(3'd0, 16'h0001);
    repeat (2) @(negedge clk);
    tb_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd4, d); chk("R11 pending edge dropped", d, 16'h0010);
    pulse(0);
    rd(3'd4, d); chk("R11 later edge counts", d, 16'h000F);

    // table: R5 R6 R7 R8
    foreach (VECS[i]) begin
      wr(3'd0, 16'h0000);
      wr(3'd2, VECS[i].bufv);
      wr(3'd0, VECS[i].ctrl);
      for (int p = 0; p < int'(VECS[i].n); p++) pulse(int'(VECS[i].src));
      chk("R6 irq", {15'd0, irq}, {15'd0, VECS[i].irq});
      rd(3'd4, d); chk("R5 count", d, VECS[i].cnt);
      rd(3'd0, d); chk("R8 status before clear", d, VECS[i].stat);
      rd(3'd0, d); chk("R8 status after clear", d, VECS[i].stat & 16'h7F7F);
      chk("R8 irq dropped", {15'd0, irq}, 16'h0000);
    end

    // R1 reset mid-run
    wr(3'd0, 16'h0001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(3'd0, d); chk("R1 reset status", d, 16'h0000);
    rd(3'd4, d); chk("R1 reset counter", d, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule